// File: doc/BRIEF.md
# Windowed Instruction Register File Controller

This block holds a small register file of frequently executed instruction words and splits it into several hardware windows. A 2-bit window pointer picks the active window, and 5-bit indexes from packed instruction formats read entries of that window through a combinational read port. Software-visible window changes happen only through control transfers. A call target carries the wanted window number in its two upper bits. The block strips those bits before the address goes to the program counter, and it folds the caller's window number into the link word that is stored as the return address. A return takes the window number back out of that link word. Window changes therefore do not follow a stack discipline, and any window can be entered from any other.

Index 0 always yields the no-operation word. A configurable number of entries directly above index 0 are static: one shared copy serves every window. A load port writes any entry of any named window, so inactive windows can be filled ahead of use.

Top module: `wirf_ctrl`

## Requirements
- R1: After reset the window pointer is 0 and every index reads as 0 in the active window.
- R2: When `call_vld` is high, `wp` takes `call_tgt[31:30]` on the next clock edge, and `call_pc` equals `call_tgt` with bits 31:30 forced to 0 in the same cycle. With no call and no return, `wp` holds.
- R3: While `call_vld` is high, `call_link` equals the current (pre-call) `wp` in bits 31:30 and `call_ret_addr[29:0]` in bits 29:0.
- R4: When `ret_vld` is high alone, `wp` takes `ret_link[31:30]` on the next edge, and `ret_pc` equals `ret_link` with bits 31:30 forced to 0 in the same cycle.
- R5: Every one of the 16 ordered pairs of windows (old, new) can be switched directly by a call.
- R6: Indexes 1 through `STATIC_CNT` (default 4) read the same value in every window; a load to such an index through any window updates it for all windows.
- R7: Index 0 reads `NOP_WORD` (default 0) in every window, and loads to index 0 have no effect.
- R8: In a cycle where a call or return is presented, `rd_data` already comes from the window being entered.
- R9: A load writes entry `ld_idx` of window `ld_win` whatever the active window; the same index of other windows is unchanged.
- R10: When a call and a return arrive in the same cycle, the call decides the new window.
- R11: Loaded data is visible on the read port from the cycle after the load; a read of the same entry in the load cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_vld | input | 1 | A call is taken this cycle |
| call_tgt | input | 32 | Call target; bits 31:30 hold the window number |
| call_ret_addr | input | 32 | Return address of the call |
| call_pc | output | 32 | Call target with window bits cleared |
| call_link | output | 32 | Link word: caller window in 31:30, return address in 29:0 |
| ret_vld | input | 1 | A return is taken this cycle |
| ret_link | input | 32 | Saved link word of the return |
| ret_pc | output | 32 | Return address with window bits cleared |
| ld_en | input | 1 | Load strobe |
| ld_win | input | 2 | Window the load writes |
| ld_idx | input | 5 | Entry index of the load |
| ld_data | input | 32 | Word to load |
| rd_idx | input | 5 | Read index |
| rd_data | output | 32 | Word at the read index of the effective window |
| wp | output | 2 | Active window pointer |

## Verification
Reads overlap both window switches and loads: the bench presents a read together with each of the 16 possible calls and checks that the word comes from the incoming window in that cycle, then asserts a read of an entry in the very cycle it is loaded and expects the old word before the new one appears a cycle later. A call and a return are also driven together to judge the arbitration by the pointer that results. Expected words come from an arithmetic pattern of window and index, with static entries expected to carry the last window's pattern after the full preload.

// File: rtl/wirf_pkg.sv
package wirf_pkg;

    localparam int WIN_CNT = 4;
    localparam int WP_W    = $clog2(WIN_CNT);
    localparam int IDX_W   = 5;
    localparam int ENT_CNT = 1 << IDX_W;
    localparam int ADDR_W  = 32;

    typedef logic [WP_W-1:0]   wp_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SW_HOLD = 2'd0,
        SW_CALL = 2'd1,
        SW_RET  = 2'd2
    } sw_kind_e;

    typedef struct packed {
        sw_kind_e kind;
        wp_t      win;
    } sw_req_t;

    function automatic wp_t addr_win(addr_t a);
        return a[ADDR_W-1 -: WP_W];
    endfunction

    function automatic addr_t addr_strip(addr_t a);
        addr_t m;
        m = '1;
        m[ADDR_W-1 -: WP_W] = '0;
        return a & m;
    endfunction

    function automatic addr_t link_pack(wp_t w, addr_t a);
        addr_t r;
        r = addr_strip(a);
        r[ADDR_W-1 -: WP_W] = w;
        return r;
    endfunction

endpackage

// File: rtl/wirf_link.sv
module wirf_link
    import wirf_pkg::*;
(
    input  logic    call_vld,
    input  addr_t   call_tgt,
    input  addr_t   call_ret_addr,
    input  logic    ret_vld,
    input  addr_t   ret_link,
    input  wp_t     cur_wp,
    output addr_t   call_pc,
    output addr_t   call_link,
    output addr_t   ret_pc,
    output sw_req_t req
);

    // Call outranks return when both arrive together.
    always_comb begin
        req.kind = SW_HOLD;
        req.win  = cur_wp;
        if (call_vld) begin
            req.kind = SW_CALL;
            req.win  = addr_win(call_tgt);
        end else if (ret_vld) begin
            req.kind = SW_RET;
            req.win  = addr_win(ret_link);
        end
    end

    assign call_pc   = addr_strip(call_tgt);
    assign call_link = link_pack(cur_wp, call_ret_addr);
    assign ret_pc    = addr_strip(ret_link);

endmodule

// File: rtl/wirf_wptr.sv
module wirf_wptr
    import wirf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sw_req_t req,
    input  logic    call_vld,
    input  addr_t   call_tgt,
    input  logic    ret_vld,
    input  addr_t   ret_link,
    output wp_t     wp_q,
    output wp_t     wp_eff
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
        end else if (req.kind != SW_HOLD) begin
            wp_q <= req.win;
        end
    end

    // Reads see the window being entered in the switch cycle.
    assign wp_eff = (req.kind != SW_HOLD) ? req.win : wp_q;

    a_r2_call_sets_wp: assert property (@(posedge clk) disable iff (rst)
        call_vld |=> (wp_q == $past(call_tgt[ADDR_W-1 -: WP_W])));

    a_r4_ret_restores_wp: assert property (@(posedge clk) disable iff (rst)
        (ret_vld && !call_vld) |=> (wp_q == $past(ret_link[ADDR_W-1 -: WP_W])));

    a_r2_idle_holds_wp: assert property (@(posedge clk) disable iff (rst)
        (!call_vld && !ret_vld) |=> $stable(wp_q));

endmodule

// File: rtl/wirf_store.sv
module wirf_store
    import wirf_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter int          STATIC_CNT = 4,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  wp_t               ld_win,
    input  idx_t              ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  wp_t               rd_win,
    input  idx_t              rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    localparam int   WIN_BASE = STATIC_CNT + 1;
    localparam int   WIN_ENT  = ENT_CNT - WIN_BASE;
    localparam idx_t LAST_STAT = idx_t'(STATIC_CNT);
    localparam idx_t BASE_IDX  = idx_t'(WIN_BASE);

    typedef enum logic [1:0] {RG_NOP, RG_STAT, RG_WIN} region_e;

    function automatic region_e region_of(idx_t i);
        if (i == '0)            return RG_NOP;
        else if (i <= LAST_STAT) return RG_STAT;
        else                     return RG_WIN;
    endfunction

    region_e rd_rg, ld_rg;
    assign rd_rg = region_of(rd_idx);
    assign ld_rg = region_of(ld_idx);

    idx_t rd_off, ld_off;
    assign rd_off = (rd_rg == RG_WIN) ? (rd_idx - BASE_IDX) : '0;
    assign ld_off = (ld_rg == RG_WIN) ? (ld_idx - BASE_IDX) : '0;

    logic [WORD_W-1:0]              stat_rd;
    logic [WIN_CNT-1:0][WORD_W-1:0] bank_rd;

    // Shared entries: one copy for all windows.
    generate
        if (STATIC_CNT > 0) begin : g_stat
            logic [WORD_W-1:0] stat_q [STATIC_CNT];
            idx_t rd_s, ld_s;
            assign rd_s = (rd_rg == RG_STAT) ? (rd_idx - idx_t'(1)) : '0;
            assign ld_s = (ld_rg == RG_STAT) ? (ld_idx - idx_t'(1)) : '0;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < STATIC_CNT; k++) stat_q[k] <= '0;
                end else if (ld_en && ld_rg == RG_STAT) begin
                    stat_q[ld_s] <= ld_data;
                end
            end
            assign stat_rd = stat_q[rd_s];
        end else begin : g_nostat
            assign stat_rd = NOP_WORD;
        end
    endgenerate

    // Per-window banks hold only the non-shared entries.
    generate
        for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
            logic [WORD_W-1:0] bank_q [WIN_ENT];
            logic              wr_hit;
            assign wr_hit = ld_en && (ld_rg == RG_WIN) && (ld_win == wp_t'(w));

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < WIN_ENT; k++) bank_q[k] <= '0;
                end else if (wr_hit) begin
                    bank_q[ld_off] <= ld_data;
                end
            end
            assign bank_rd[w] = bank_q[rd_off];
        end
    endgenerate

    always_comb begin
        unique case (rd_rg)
            RG_NOP:  rd_data = NOP_WORD;
            RG_STAT: rd_data = stat_rd;
            default: rd_data = bank_rd[rd_win];
        endcase
    end

    a_r7_entry0_nop: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == '0) |-> (rd_data == NOP_WORD));

    a_r6_static_shared: assert property (@(posedge clk) disable iff (rst)
        ((rd_idx != '0) && (rd_idx <= LAST_STAT) && $stable(rd_idx) && !$past(ld_en))
        |-> $stable(rd_data));

    a_r9_load_lands: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_idx != '0) |=>
        (((rd_idx == $past(ld_idx)) &&
          ((rd_win == $past(ld_win)) || ($past(ld_idx) <= LAST_STAT)))
         -> (rd_data == $past(ld_data))));

endmodule

// File: rtl/wirf_ctrl.sv
module wirf_ctrl
    import wirf_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter int          STATIC_CNT = 4,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_vld,
    input  logic [31:0]       call_tgt,
    input  logic [31:0]       call_ret_addr,
    output logic [31:0]       call_pc,
    output logic [31:0]       call_link,
    input  logic              ret_vld,
    input  logic [31:0]       ret_link,
    output logic [31:0]       ret_pc,
    input  logic              ld_en,
    input  logic [1:0]        ld_win,
    input  logic [4:0]        ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [4:0]        rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [1:0]        wp
);

    sw_req_t req;
    wp_t     wp_q;
    wp_t     wp_eff;

    wirf_link u_link (
        .call_vld      (call_vld),
        .call_tgt      (call_tgt),
        .call_ret_addr (call_ret_addr),
        .ret_vld       (ret_vld),
        .ret_link      (ret_link),
        .cur_wp        (wp_q),
        .call_pc       (call_pc),
        .call_link     (call_link),
        .ret_pc        (ret_pc),
        .req           (req)
    );

    wirf_wptr u_wptr (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .call_vld (call_vld),
        .call_tgt (call_tgt),
        .ret_vld  (ret_vld),
        .ret_link (ret_link),
        .wp_q     (wp_q),
        .wp_eff   (wp_eff)
    );

    wirf_store #(
        .WORD_W     (WORD_W),
        .STATIC_CNT (STATIC_CNT),
        .NOP_WORD   (NOP_WORD)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_win  (ld_win),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .rd_win  (wp_eff),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign wp = wp_q;

    a_r10_call_wins: assert property (@(posedge clk) disable iff (rst)
        (call_vld && ret_vld) |=> (wp == $past(call_tgt[31:30])));

    a_r3_link_holds_caller: assert property (@(posedge clk) disable iff (rst)
        call_vld |-> (call_link[31:30] == wp));

endmodule

// File: tb/sim_wirf_ctrl.sv
module sim_wirf_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_vld;
    logic [31:0] call_tgt, call_ret_addr, call_pc, call_link;
    logic        ret_vld;
    logic [31:0] ret_link, ret_pc;
    logic        ld_en;
    logic [1:0]  ld_win;
    logic [4:0]  ld_idx, rd_idx;
    logic [31:0] ld_data, rd_data;
    logic [1:0]  wp;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam int NSTAT = 4;

    wirf_ctrl u0 (
        .clk(clk), .rst(rst),
        .call_vld(call_vld), .call_tgt(call_tgt), .call_ret_addr(call_ret_addr),
        .call_pc(call_pc), .call_link(call_link),
        .ret_vld(ret_vld), .ret_link(ret_link), .ret_pc(ret_pc),
        .ld_en(ld_en), .ld_win(ld_win), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .wp(wp)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(int w, int i);
        return {8'hC0 + 8'(w), 8'(i), 16'(w * 1000 + i * 7)};
    endfunction

    // Expected read of index i in window w after the full preload.
    function automatic logic [31:0] exp_rd(int w, int i);
        if (i == 0)          return 32'h0;
        else if (i <= NSTAT) return pat(3, i);
        else                 return pat(w, i);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc;
        @(posedge clk);
        #2;
    endtask

    task automatic set_wp(int w);
        call_vld = 1'b1;
        call_tgt = {2'(w), 30'h40};
        cyc();
        call_vld = 1'b0;
    endtask

    initial begin
        rst = 1'b1; call_vld = 0; call_tgt = 0; call_ret_addr = 0;
        ret_vld = 0; ret_link = 0; ld_en = 0; ld_win = 0; ld_idx = 0;
        ld_data = 0; rd_idx = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1: reset state
        chk("R1 wp after reset", 32'(wp), 32'h0);
        for (int i = 0; i < 32; i++) begin
            rd_idx = 5'(i); #1;
            chk("R1 entry after reset", rd_data, 32'h0);
        end

        // R11: same-cycle read sees old word, next cycle new word
        ld_en = 1; ld_win = 0; ld_idx = 10; ld_data = 32'h1234_5678; rd_idx = 10; #1;
        chk("R11 read in load cycle", rd_data, 32'h0);
        cyc(); ld_en = 0; #1;
        chk("R11 read after load", rd_data, 32'h1234_5678);

        // R9: preload every window while window 0 is active
        for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < 32; i++) begin
                ld_en = 1; ld_win = 2'(w); ld_idx = 5'(i); ld_data = pat(w, i);
                cyc();
            end
        end
        ld_en = 0;
        chk("R9 wp unchanged by loads", 32'(wp), 32'h0);

        // R2 R3 R5 R8: every ordered window pair
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                set_wp(f);
                call_vld = 1;
                call_tgt = {2'(t), 30'h0000_1234 + 30'(f * 16 + t)};
                call_ret_addr = {2'b11, 30'h0ABC_0000 + 30'(t * 4 + f)};
                rd_idx = 5'(5 + f * 4 + t);
                #1;
                chk("R8 read in switch cycle", rd_data, exp_rd(t, 5 + f * 4 + t));
                chk("R2 call_pc stripped", call_pc, {2'b00, call_tgt[29:0]});
                chk("R3 link word", call_link, {2'(f), call_ret_addr[29:0]});
                cyc();
                call_vld = 0;
                chk("R5 wp after call", 32'(wp), 32'(t));
                for (int i = 0; i < 32; i++) begin
                    rd_idx = 5'(i); #1;
                    if (i == 0)          chk("R7 entry0 nop", rd_data, exp_rd(t, i));
                    else if (i <= NSTAT) chk("R6 static entry", rd_data, exp_rd(t, i));
                    else                 chk("R9 window entry", rd_data, exp_rd(t, i));
                end
                cyc();
                chk("R2 wp holds when idle", 32'(wp), 32'(t));
            end
        end

        // R4: return restores window from link word
        set_wp(2);
        ret_vld = 1; ret_link = {2'd1, 30'h0ABC_DEF0}; rd_idx = 20; #1;
        chk("R8 read in return cycle", rd_data, pat(1, 20));
        chk("R4 ret_pc stripped", ret_pc, {2'b00, 30'h0ABC_DEF0});
        cyc(); ret_vld = 0;
        chk("R4 wp after return", 32'(wp), 32'h1);

        // R10: call and return together
        call_vld = 1; call_tgt = {2'd3, 30'h80};
        ret_vld = 1; ret_link = {2'd0, 30'h90}; rd_idx = 25; #1;
        chk("R10 read window on clash", rd_data, pat(3, 25));
        cyc(); call_vld = 0; ret_vld = 0;
        chk("R10 call wins", 32'(wp), 32'h3);

        // R7: load to index 0 ignored
        ld_en = 1; ld_win = 2; ld_idx = 0; ld_data = 32'hFFFF_FFFF;
        cyc(); ld_en = 0;
        set_wp(2); rd_idx = 0; #1;
        chk("R7 entry0 after load", rd_data, 32'h0);

        // R6: static entry loaded via window 1, seen in all
        ld_en = 1; ld_win = 1; ld_idx = 2; ld_data = 32'h5A5A_0002;
        cyc(); ld_en = 0;
        for (int w = 0; w < 4; w++) begin
            set_wp(w); rd_idx = 2; #1;
            chk("R6 shared after load", rd_data, 32'h5A5A_0002);
        end

        // R9: load inactive window 1 while window 3 active
        ld_en = 1; ld_win = 1; ld_idx = 20; ld_data = 32'hBEEF_0020;
        cyc(); ld_en = 0;
        rd_idx = 20; #1;
        chk("R9 active window untouched", rd_data, pat(3, 20));
        set_wp(0); rd_idx = 20; #1;
        chk("R9 other window untouched", rd_data, pat(0, 20));
        set_wp(1); rd_idx = 20; #1;
        chk("R9 target window loaded", rd_data, 32'hBEEF_0020);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule